// File: doc/BRIEF.md
# Serial Flash Block Erase Command Unit

This unit is the device-side command logic that handles region erase on a serial flash slave. It watches the serial bit stream of one chip-select frame, recognises the three erase opcodes, collects the 24-bit target address and decides at the end of the frame whether an erase may start. The serial interface reaches it already sampled into the system clock: a bit strobe with its data bit, and an active-low select.

An erase starts only when the select is released. At that point the frame must have carried the complete address and ended on a whole byte. The write-enable latch must have been set when the frame began, and the protection lookup must clear the aligned target. If all of these hold, the unit issues a one-cycle request carrying the block-aligned base address and a size code. It also raises busy until the erase engine reports completion. If an erase frame fails any of the checks, the write-enable latch is cleared and nothing is erased. The protection table is outside the unit: it is given the masked base address and answers in the same cycle.

Top module: `spi_erase_ctrl`

## Requirements
- R1: Opcode 0x20 requests a 4 KB erase (size code 0), 0x52 requests a 32 KB erase (size code 1) and 0xD8 requests a 64 KB erase (size code 2); size code 3 never appears. Any other opcode, or a frame that ends before the first 8 bits are in, causes no request and leaves the write-enable latch unchanged.
- R2: An erase frame is acted on only if the write-enable latch was 1 when the select fell; otherwise it causes no request. A one-cycle `wel_set` pulse sets the latch when the unit is idle.
- R3: Bits are taken MSB first: 8 opcode bits, then 24 address bits. Whole bytes after the address do not alter the captured address.
- R4: The request is never raised while the select is low. It is a single-cycle pulse in the cycle after the first clock edge that samples the select high.
- R5: The request base equals the address with bits 11..0 cleared for size 0, bits 14..0 cleared for size 1 and bits 15..0 cleared for size 2.
- R6: An erase frame released with fewer than 32 bits, or with a bit count that is not a multiple of 8, causes no request and clears the write-enable latch.
- R7: `prot_addr` presents the masked base of the frame. If `prot_hit` is 1 in the release cycle, there is no request and the write-enable latch is cleared.
- R8: On a request, busy becomes 1 and the write-enable latch becomes 0 in the same cycle. Busy returns to 0 on the edge that samples `erase_done` high.
- R9: While busy, `wel_set` is ignored, and any frame whose select fell while busy causes no request.
- R10: After reset, busy, the write-enable latch and the request are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select, sampled in clk |
| bit_vld | input | 1 | One-cycle strobe marking a new serial bit |
| bit_in | input | 1 | Serial data bit accompanying bit_vld |
| wel_set | input | 1 | Pulse from the write-enable command |
| erase_done | input | 1 | Pulse from the erase engine at completion |
| prot_hit | input | 1 | Protection lookup result for prot_addr |
| prot_addr | output | 24 | Block-aligned base for the protection lookup |
| erase_req | output | 1 | One-cycle erase start request |
| erase_base | output | 24 | Aligned base address of the erase |
| erase_size | output | 2 | Size code of the erase |
| busy | output | 1 | Erase in progress |
| wel | output | 1 | Write-enable latch |

## Verification
The assertions check on every cycle the properties a single clock step can show. The request lasts one cycle and follows a select release. It coincides with busy set and the latch clear, never follows a busy cycle, and carries a base aligned for its size code. Busy drops after done, and the latch cannot rise while busy. Only the bench scenarios can show the frame-level decisions, because each depends on the whole bit history of a frame. These decisions are the rejection of short or misaligned frames, the protection veto, the need for the latch at frame start, and the absence of effect from unknown opcodes and trailing bytes. The scoreboard confirms that each request carries the expected base and size and that no request appears where none is expected.

// File: rtl/spi_erase_pkg.sv
package spi_erase_pkg;

   typedef enum logic [1:0] {
      SZ_4K   = 2'd0,
      SZ_32K  = 2'd1,
      SZ_64K  = 2'd2,
      SZ_NONE = 2'd3
   } ers_size_e;

   localparam logic [7:0] OP_ERS_4K  = 8'h20;
   localparam logic [7:0] OP_ERS_32K = 8'h52;
   localparam logic [7:0] OP_ERS_64K = 8'hD8;

   // number of low address bits dropped per block size
   localparam int unsigned LOW_4K  = 12;
   localparam int unsigned LOW_32K = 15;
   localparam int unsigned LOW_64K = 16;

   function automatic ers_size_e decode_op(input logic [7:0] op);
      case (op)
         OP_ERS_4K:  return SZ_4K;
         OP_ERS_32K: return SZ_32K;
         OP_ERS_64K: return SZ_64K;
         default:    return SZ_NONE;
      endcase
   endfunction

endpackage

// File: rtl/spi_erase_frame.sv
module spi_erase_frame #(
   parameter int unsigned ADDR_W = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              bit_vld,
   input  logic              bit_in,
   output logic [7:0]        op_q,
   output logic [ADDR_W-1:0] addr_q,
   output logic              op_have,
   output logic              addr_full,
   output logic              byte_aligned,
   output logic              cs_rise
);
   localparam int unsigned ADDR_BYTES  = ADDR_W / 8;
   localparam int unsigned FRAME_BYTES = ADDR_BYTES + 1;
   localparam int unsigned CNT_W       = $clog2(FRAME_BYTES + 1);

   logic             cs_q;
   logic [2:0]       bit_cnt;
   logic [CNT_W-1:0] byte_cnt;
   logic [6:0]       sh;
   logic [7:0]       byte_now;

   assign byte_now = {sh, bit_in};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_q     <= 1'b1;
         bit_cnt  <= '0;
         byte_cnt <= '0;
         sh       <= '0;
         op_q     <= '0;
         addr_q   <= '0;
      end else begin
         cs_q <= cs_n;
         if (cs_n) begin
            bit_cnt  <= '0;
            byte_cnt <= '0;
         end else if (bit_vld) begin
            bit_cnt <= bit_cnt + 3'd1;
            sh      <= byte_now[6:0];
            if (bit_cnt == 3'd7 && byte_cnt != CNT_W'(FRAME_BYTES)) begin
               byte_cnt <= byte_cnt + CNT_W'(1);
               if (byte_cnt == '0)
                  op_q <= byte_now;
               else
                  addr_q <= {addr_q[ADDR_W-9:0], byte_now};
            end
         end
      end
   end

   assign op_have      = (byte_cnt != '0);
   assign addr_full    = (byte_cnt == CNT_W'(FRAME_BYTES));
   assign byte_aligned = (bit_cnt == 3'd0);
   assign cs_rise      = !cs_q && cs_n;

endmodule

// File: rtl/spi_erase_decode.sv
module spi_erase_decode
   import spi_erase_pkg::*;
#(
   parameter int unsigned ADDR_W = 24
) (
   input  logic [7:0]        op,
   input  logic [ADDR_W-1:0] addr,
   output ers_size_e         size,
   output logic              is_erase,
   output logic [ADDR_W-1:0] base
);
   assign size     = decode_op(op);
   assign is_erase = (size != SZ_NONE);

   for (genvar i = 0; i < ADDR_W; i++) begin : g_mask
      localparam bit IN_4K  = (i < LOW_4K);
      localparam bit IN_32K = (i < LOW_32K);
      localparam bit IN_64K = (i < LOW_64K);
      logic drop;
      assign drop = (size == SZ_4K  && IN_4K)  ||
                    (size == SZ_32K && IN_32K) ||
                    (size == SZ_64K && IN_64K);
      assign base[i] = addr[i] & ~drop;
   end

endmodule

// File: rtl/spi_erase_seq.sv
module spi_erase_seq
   import spi_erase_pkg::*;
#(
   parameter int unsigned ADDR_W = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              cs_rise,
   input  logic              op_have,
   input  logic              is_erase,
   input  logic              addr_full,
   input  logic              byte_aligned,
   input  logic              prot_hit,
   input  logic [ADDR_W-1:0] base,
   input  ers_size_e         size,
   input  logic              wel_set,
   input  logic              erase_done,
   output logic              erase_req,
   output logic [ADDR_W-1:0] erase_base,
   output logic [1:0]        erase_size,
   output logic              busy,
   output logic              wel
);
   logic wel_snap, busy_snap;
   logic cmd_live, frame_ok, accept, abort_cmd;
   logic wel_nxt, busy_nxt;

   assign cmd_live  = op_have && is_erase && wel_snap && !busy_snap;
   assign frame_ok  = addr_full && byte_aligned && !prot_hit;
   assign accept    = cs_rise && cmd_live && frame_ok;
   assign abort_cmd = cs_rise && cmd_live && !frame_ok;

   always_comb begin
      busy_nxt = busy;
      if (accept)
         busy_nxt = 1'b1;
      else if (busy && erase_done)
         busy_nxt = 1'b0;

      wel_nxt = wel;
      if (accept || abort_cmd)
         wel_nxt = 1'b0;
      else if (wel_set && !busy)
         wel_nxt = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy       <= 1'b0;
         wel        <= 1'b0;
         wel_snap   <= 1'b0;
         busy_snap  <= 1'b0;
         erase_req  <= 1'b0;
         erase_base <= '0;
         erase_size <= '0;
      end else begin
         busy      <= busy_nxt;
         wel       <= wel_nxt;
         erase_req <= accept;
         if (cs_n) begin
            wel_snap  <= wel_nxt;
            busy_snap <= busy_nxt;
         end
         if (accept) begin
            erase_base <= base;
            erase_size <= size;
         end
      end
   end

endmodule

// File: rtl/spi_erase_ctrl.sv
module spi_erase_ctrl
   import spi_erase_pkg::*;
#(
   parameter int unsigned ADDR_W = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              bit_vld,
   input  logic              bit_in,
   input  logic              wel_set,
   input  logic              erase_done,
   input  logic              prot_hit,
   output logic [ADDR_W-1:0] prot_addr,
   output logic              erase_req,
   output logic [ADDR_W-1:0] erase_base,
   output logic [1:0]        erase_size,
   output logic              busy,
   output logic              wel
);
   if ((ADDR_W % 8) != 0 || ADDR_W < 16) begin : g_bad_addr_w
      $error("spi_erase_ctrl: ADDR_W must be a multiple of 8 and at least 16");
   end

   logic [7:0]        op_q;
   logic [ADDR_W-1:0] addr_q;
   logic              op_have, addr_full, byte_aligned, cs_rise;
   ers_size_e         size;
   logic              is_erase;
   logic [ADDR_W-1:0] base;

   spi_erase_frame #(.ADDR_W(ADDR_W)) u_frame (
      .clk          (clk),
      .rst_n        (rst_n),
      .cs_n         (cs_n),
      .bit_vld      (bit_vld),
      .bit_in       (bit_in),
      .op_q         (op_q),
      .addr_q       (addr_q),
      .op_have      (op_have),
      .addr_full    (addr_full),
      .byte_aligned (byte_aligned),
      .cs_rise      (cs_rise)
   );

   spi_erase_decode #(.ADDR_W(ADDR_W)) u_dec (
      .op       (op_q),
      .addr     (addr_q),
      .size     (size),
      .is_erase (is_erase),
      .base     (base)
   );

   assign prot_addr = base;

   spi_erase_seq #(.ADDR_W(ADDR_W)) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .cs_n         (cs_n),
      .cs_rise      (cs_rise),
      .op_have      (op_have),
      .is_erase     (is_erase),
      .addr_full    (addr_full),
      .byte_aligned (byte_aligned),
      .prot_hit     (prot_hit),
      .base         (base),
      .size         (size),
      .wel_set      (wel_set),
      .erase_done   (erase_done),
      .erase_req    (erase_req),
      .erase_base   (erase_base),
      .erase_size   (erase_size),
      .busy         (busy),
      .wel          (wel)
   );

endmodule

// File: rtl/spi_erase_ctrl_chk.sv
module spi_erase_ctrl_chk #(
   parameter int unsigned ADDR_W = 24
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cs_n,
   input logic              wel_set,
   input logic              erase_done,
   input logic              erase_req,
   input logic [ADDR_W-1:0] erase_base,
   input logic [1:0]        erase_size,
   input logic              busy,
   input logic              wel
);
   AST_REQ_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      erase_req |=> !erase_req); // R4

   AST_REQ_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      erase_req |-> ($past(cs_n) && !$past(cs_n, 2))); // R4

   AST_REQ_SIZE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      erase_req |-> (erase_size != 2'd3)); // R1

   AST_REQ_BASE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      erase_req |-> ((erase_size == 2'd0 && erase_base[11:0] == '0) ||
                     (erase_size == 2'd1 && erase_base[14:0] == '0) ||
                     (erase_size == 2'd2 && erase_base[15:0] == '0))); // R5

   AST_REQ_BUSY_NO_WEL: assert property (@(posedge clk) disable iff (!rst_n)
      erase_req |-> (busy && !wel)); // R8

   AST_DONE_CLEARS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && erase_done) |=> !busy); // R8

   AST_NO_REQ_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      erase_req |-> !$past(busy)); // R9

   AST_WEL_HELD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !wel && wel_set) |=> !wel); // R9

endmodule

bind spi_erase_ctrl spi_erase_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cs_n       (cs_n),
   .wel_set    (wel_set),
   .erase_done (erase_done),
   .erase_req  (erase_req),
   .erase_base (erase_base),
   .erase_size (erase_size),
   .busy       (busy),
   .wel        (wel)
);

// File: tb/spi_erase_ctrl_tb.sv
module spi_erase_ctrl_tb;
   localparam int CLK_PERIOD = 10;

   typedef struct packed {
      logic [23:0] base;
      logic [1:0]  size;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_n = 1'b1;
   logic        bit_vld = 1'b0;
   logic        bit_in = 1'b0;
   logic        wel_set = 1'b0;
   logic        erase_done = 1'b0;
   logic        prot_hit;
   logic [23:0] prot_addr;
   logic        erase_req;
   logic [23:0] erase_base;
   logic [1:0]  erase_size;
   logic        busy;
   logic        wel;

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;
   exp_t exp_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   // protection table model: upper region 0x3Fxxxx is locked
   assign prot_hit = (prot_addr[23:16] == 8'h3F);

   spi_erase_ctrl u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .cs_n       (cs_n),
      .bit_vld    (bit_vld),
      .bit_in     (bit_in),
      .wel_set    (wel_set),
      .erase_done (erase_done),
      .prot_hit   (prot_hit),
      .prot_addr  (prot_addr),
      .erase_req  (erase_req),
      .erase_base (erase_base),
      .erase_size (erase_size),
      .busy       (busy),
      .wel        (wel)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && erase_req && !finished) begin
         if (exp_q.size() == 0) begin
            check("R1 R2 R6 R7 R9 unexpected erase request", {6'd0, erase_base, erase_size}, 32'd0);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            check("R1 R3 R5 request base and size", {6'd0, erase_base, erase_size}, {6'd0, e.base, e.size});
         end
      end
   end

   task automatic send(input logic [7:0] op, input logic [23:0] a, input int nbits, input int hold);
      logic [47:0] vec;
      vec = {op, a, 8'hA5, 8'h5A};
      @(negedge clk);
      cs_n = 1'b0;
      for (int i = 0; i < nbits; i++) begin
         @(negedge clk);
         bit_vld = 1'b1;
         bit_in  = vec[47-i];
      end
      @(negedge clk);
      bit_vld = 1'b0;
      for (int h = 0; h < hold; h++) begin
         @(negedge clk);
         check("R4 no request while select low", {30'd0, erase_req, busy}, 32'd0);
      end
      cs_n = 1'b1;
      @(negedge clk);
      @(negedge clk);
   endtask

   task automatic set_wel();
      @(negedge clk);
      wel_set = 1'b1;
      @(negedge clk);
      wel_set = 1'b0;
   endtask

   task automatic finish_erase();
      @(negedge clk);
      erase_done = 1'b1;
      @(negedge clk);
      erase_done = 1'b0;
      check("R8 busy cleared by done", {31'd0, busy}, 32'd0);
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         fails++;
         checks++;
         $display("FAIL watchdog expired");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R10 reset state", {29'd0, busy, wel, erase_req}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R10 idle after reset", {29'd0, busy, wel, erase_req}, 32'd0);

      // R2: no latch -> nothing
      send(8'h20, 24'h001234, 32, 0);
      check("R2 no erase without latch", {30'd0, busy, wel}, 32'd0);

      // R2, R4, R5, R8: 4 KB erase
      set_wel();
      check("R2 latch set", {31'd0, wel}, 32'd1);
      exp_q.push_back('{base: 24'h123000, size: 2'd0});
      send(8'h20, 24'h123456, 32, 3);
      check("R8 busy set and latch cleared", {30'd0, busy, wel}, 32'd2);
      finish_erase();

      // R5: 32 KB erase
      set_wel();
      exp_q.push_back('{base: 24'h128000, size: 2'd1});
      send(8'h52, 24'h12FFFF, 32, 0);
      check("R8 busy after 32K", {30'd0, busy, wel}, 32'd2);
      finish_erase();

      // R3: 64 KB erase with two trailing bytes
      set_wel();
      exp_q.push_back('{base: 24'h120000, size: 2'd2});
      send(8'hD8, 24'h12ABCD, 48, 0);
      check("R3 trailing bytes accepted", {30'd0, busy, wel}, 32'd2);
      finish_erase();

      // R6: incomplete address
      set_wel();
      send(8'h20, 24'h010000, 24, 0);
      check("R6 short frame aborts", {30'd0, busy, wel}, 32'd0);

      // R6: misaligned release
      set_wel();
      send(8'h20, 24'h000000, 35, 0);
      check("R6 misaligned frame aborts", {30'd0, busy, wel}, 32'd0);

      // R7: protected target
      set_wel();
      send(8'h20, 24'h3F1ABC, 32, 0);
      check("R7 protected target aborts", {30'd0, busy, wel}, 32'd0);

      // R9: commands ignored while busy
      set_wel();
      exp_q.push_back('{base: 24'h000000, size: 2'd0});
      send(8'h20, 24'h000FFF, 32, 0);
      set_wel();
      check("R9 latch not set while busy", {30'd0, busy, wel}, 32'd2);
      send(8'h52, 24'h200000, 32, 0);
      check("R9 frame ignored while busy", {30'd0, busy, wel}, 32'd2);
      finish_erase();

      // R1: other opcode and a short opcode leave the latch alone
      set_wel();
      send(8'h03, 24'h000100, 32, 0);
      check("R1 unknown opcode no effect", {30'd0, busy, wel}, 32'd1);
      send(8'h20, 24'h000000, 4, 0);
      check("R1 partial opcode no effect", {30'd0, busy, wel}, 32'd1);

      repeat (4) @(negedge clk);
      check("R4 R8 all expected requests seen", exp_q.size(), 32'd0);

      finished = 1'b1;
      summary();
      $finish;
   end

endmodule